// File: doc/BRIEF.md
# SDRAM Data Mask and Clock-Suspend Aligner

This block sits in an SDRAM controller next to the command path. It turns per-beat byte-lane mask requests for a read or write burst into correctly timed DQM pins. It also drives the CKE pin from a host suspend request. The host pulses a read or write start in the cycle the matching column command goes out, and presents the whole burst's mask in that cycle. The block then places each beat's mask on `dqm_o` at the lead time the device needs: two device clocks before read data, and together with the write data.

The host raises `susp_req_i` to stretch a burst. CKE drops one cycle later, and the device stops advancing the cycle after that. The block counts only cycles in which the device advances. Frozen cycles therefore move neither the beat position nor the mask timing, and no beat is reported in them. On the host side the block flags the cycle in which each read beat arrives, along with the lanes to keep, so that masked read data can be discarded. It also flags the cycles in which write data is taken.

Top module: `sdram_mask_aligner`

## Requirements
- R1: `cke_o` is high out of reset, and in every later cycle it equals the inverse of `susp_req_i` from the previous cycle.
- R2: A cycle is a device tick only if `cke_o` was high in the preceding cycle. The start cycle is tick 0, and the tick number rises by one on each later device tick.
- R3: During a write, at tick k (0 to BL-1), `dqm_o` carries the mask of beat k, taken from `mask_i[k*LANES +: LANES]`, where 1 means the lane is masked.
- R4: During a read, at tick CL-2+k (0 <= k < BL), `dqm_o` carries the mask of beat k. This is two device clocks ahead of that beat's data.
- R5: During a read, `rd_beat_o` is high on device ticks CL to CL+BL-1. In those cycles `rd_keep_o` is the inverse of that beat's mask, and in all other cycles it is zero.
- R6: During a write, `wr_beat_o` is high on device ticks 0 to BL-1 and low otherwise.
- R7: Outside its mask window a burst drives `dqm_o` to zero. Once the burst's last tick has passed (tick BL-1 for a write, CL+BL-1 for a read), the block is idle, and a new start is accepted in the very next cycle.
- R8: In a cycle that is not a device tick, no beat is flagged and `dqm_o` holds its value from the previous cycle.
- R9: An active-low asynchronous reset discards any burst in progress and returns `cke_o` high and all other outputs low.
- R10: The mask is captured in the start cycle. Later changes on `mask_i` do not affect the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_start_i | input | 1 | Read burst begins this cycle |
| wr_start_i | input | 1 | Write burst begins this cycle |
| mask_i | input | BL*LANES | Per-beat lane masks, beat k at bits k*LANES+:LANES |
| susp_req_i | input | 1 | Host request to suspend the device clock |
| cke_o | output | 1 | Clock enable pin |
| dqm_o | output | LANES | Data mask pins, one per byte lane |
| rd_beat_o | output | 1 | A read beat arrives this cycle |
| rd_keep_o | output | LANES | Lanes of the arriving read beat to keep |
| wr_beat_o | output | 1 | Write data is taken this cycle |

## Verification
The assertions take three things for granted about the host. It starts a burst only when the block is idle. It never raises read and write start together. It starts only in a cycle that is a device tick, which means `cke_o` was high in the cycle before. The stimulus keeps to this in two ways. Each burst begins either after a settling gap, during which the suspend request is low long enough for CKE to return high, or in the cycle right after the previous burst's last tick. Suspend windows only ever begin at or after the start cycle.

// File: rtl/sdram_align_pkg.sv
package sdram_align_pkg;
  typedef enum logic {
    DIR_WR = 1'b0,
    DIR_RD = 1'b1
  } burst_dir_e;
endpackage

// File: rtl/sdram_cke_ctrl.sv
module sdram_cke_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic susp_req_i,
  output logic cke_o,
  output logic adv_o
);
  logic cke_q, cke_d1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q    <= 1'b1;
      cke_d1_q <= 1'b1;
    end else begin
      cke_q    <= ~susp_req_i;
      cke_d1_q <= cke_q;
    end
  end

  assign cke_o = cke_q;
  // device samples CKE one edge before the edge it gates
  assign adv_o = cke_d1_q;

  // R1
  susp_cke_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_req_i |=> !cke_o);
  // R2
  frz_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |=> !adv_o);
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_align_pkg::*;
#(
  parameter int BL    = 4,
  parameter int LANES = 2,
  parameter int CL    = 2,
  localparam int MW   = BL * LANES,
  localparam int TW   = $clog2(CL + BL + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_start_i,
  input  logic          wr_start_i,
  input  logic [MW-1:0] mask_i,
  input  logic          adv_i,
  output logic          act_o,
  output burst_dir_e    dir_o,
  output logic [TW-1:0] tick_o,
  output logic [MW-1:0] mask_o
);
  localparam logic [TW-1:0] LastRd = TW'(CL + BL - 1);
  localparam logic [TW-1:0] LastWr = TW'(BL - 1);

  logic          busy_q;
  burst_dir_e    dir_q;
  logic [TW-1:0] cnt_q;
  logic [MW-1:0] mask_q;
  logic          start, done;
  logic [TW-1:0] last;

  assign start = rd_start_i | wr_start_i;

  always_comb begin
    if (start) begin
      tick_o = '0;
      dir_o  = rd_start_i ? DIR_RD : DIR_WR;
      mask_o = mask_i;
    end else begin
      tick_o = adv_i ? cnt_q + TW'(1) : cnt_q;
      dir_o  = dir_q;
      mask_o = mask_q;
    end
  end

  assign act_o = start | busy_q;
  assign last  = (dir_o == DIR_RD) ? LastRd : LastWr;
  assign done  = act_o & adv_i & (tick_o == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      dir_q  <= DIR_WR;
      cnt_q  <= '0;
      mask_q <= '0;
    end else begin
      busy_q <= act_o & ~done;
      if (act_o) cnt_q <= tick_o;
      if (start) begin
        dir_q  <= dir_o;
        mask_q <= mask_i;
      end
    end
  end

  // R7
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> !busy_q);
  // R7
  one_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_start_i && wr_start_i));
  // R2
  start_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> adv_i);
  // R8
  tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !adv_i) |-> tick_o == $past(tick_o));
endmodule

// File: rtl/sdram_dqm_sel.sv
module sdram_dqm_sel
  import sdram_align_pkg::*;
#(
  parameter int BL    = 4,
  parameter int LANES = 2,
  parameter int CL    = 2,
  localparam int MW   = BL * LANES,
  localparam int TW   = $clog2(CL + BL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  burst_dir_e       dir_i,
  input  logic [TW-1:0]    tick_i,
  input  logic [MW-1:0]    mask_i,
  input  logic             adv_i,
  output logic [LANES-1:0] dqm_o,
  output logic             rd_beat_o,
  output logic [LANES-1:0] rd_keep_o,
  output logic             wr_beat_o
);
  // read mask leads data by two device clocks
  localparam int RdLead = CL - 2;

  logic is_rd, is_wr;
  assign is_rd = act_i & (dir_i == DIR_RD);
  assign is_wr = act_i & (dir_i == DIR_WR);

  always_comb begin
    dqm_o     = '0;
    rd_beat_o = 1'b0;
    rd_keep_o = '0;
    wr_beat_o = 1'b0;
    for (int k = 0; k < BL; k++) begin
      if (is_wr && int'(tick_i) == k) begin
        dqm_o     = mask_i[k*LANES +: LANES];
        wr_beat_o = adv_i;
      end
      if (is_rd && int'(tick_i) == k + RdLead)
        dqm_o = mask_i[k*LANES +: LANES];
      if (is_rd && adv_i && int'(tick_i) == k + CL) begin
        rd_beat_o = 1'b1;
        rd_keep_o = ~mask_i[k*LANES +: LANES];
      end
    end
  end

  // R8
  dqm_frz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && !adv_i) |-> $stable(dqm_o));
endmodule

// File: rtl/sdram_mask_aligner.sv
module sdram_mask_aligner
  import sdram_align_pkg::*;
#(
  parameter int BL    = 4,
  parameter int LANES = 2,
  parameter int CL    = 2,
  localparam int MW   = BL * LANES,
  localparam int TW   = $clog2(CL + BL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_start_i,
  input  logic             wr_start_i,
  input  logic [MW-1:0]    mask_i,
  input  logic             susp_req_i,
  output logic             cke_o,
  output logic [LANES-1:0] dqm_o,
  output logic             rd_beat_o,
  output logic [LANES-1:0] rd_keep_o,
  output logic             wr_beat_o
);
  logic          adv, act;
  burst_dir_e    dir;
  logic [TW-1:0] tick;
  logic [MW-1:0] mask;

  sdram_cke_ctrl u_cke (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .susp_req_i (susp_req_i),
    .cke_o      (cke_o),
    .adv_o      (adv)
  );

  sdram_burst_seq #(.BL(BL), .LANES(LANES), .CL(CL)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_start_i (rd_start_i),
    .wr_start_i (wr_start_i),
    .mask_i     (mask_i),
    .adv_i      (adv),
    .act_o      (act),
    .dir_o      (dir),
    .tick_o     (tick),
    .mask_o     (mask)
  );

  sdram_dqm_sel #(.BL(BL), .LANES(LANES), .CL(CL)) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (act),
    .dir_i     (dir),
    .tick_i    (tick),
    .mask_i    (mask),
    .adv_i     (adv),
    .dqm_o     (dqm_o),
    .rd_beat_o (rd_beat_o),
    .rd_keep_o (rd_keep_o),
    .wr_beat_o (wr_beat_o)
  );

  // R8
  rd_frz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_beat_o |-> $past(cke_o));
  // R8
  wr_frz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_beat_o |-> $past(cke_o));
  // R5
  beat_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_beat_o && wr_beat_o));
endmodule

// File: tb/sdram_mask_aligner_tb.sv
module sdram_mask_aligner_tb;
  localparam int BL = 4, LANES = 2, CL = 2, MW = BL * LANES;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic rd_start_i = 1'b0, wr_start_i = 1'b0, susp_req_i = 1'b0;
  logic [MW-1:0] mask_i = '0;
  logic cke_o, rd_beat_o, wr_beat_o;
  logic [LANES-1:0] dqm_o, rd_keep_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  sdram_mask_aligner #(.BL(BL), .LANES(LANES), .CL(CL)) u_dut (.*);

  // {is_rd, mask, susp_start_cycle, susp_len}
  localparam logic [24:0] VEC [8] = '{
    {1'b1, 8'h00, 8'd0, 8'd0},
    {1'b1, 8'h93, 8'd0, 8'd0},
    {1'b0, 8'h5A, 8'd0, 8'd0},
    {1'b0, 8'hFF, 8'd0, 8'd0},
    {1'b1, 8'h3C, 8'd1, 8'd2},
    {1'b0, 8'h96, 8'd0, 8'd3},
    {1'b1, 8'hC3, 8'd3, 8'd1},
    {1'b1, 8'h0F, 8'd4, 8'd4}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_burst(bit rd, logic [7:0] m, int st, int ln, bit settle);
    int tick = 0;
    bit prev_cke = 1'b1, prev_susp = 1'b0, adv, fin = 1'b0, exp_rb, exp_wb;
    logic [LANES-1:0] exp_dqm, exp_keep;
    int last = rd ? CL + BL - 1 : BL - 1;
    for (int c = 0; c < 100 && !fin; c++) begin
      @(posedge clk_i); #1;
      rd_start_i = rd && c == 0;
      wr_start_i = !rd && c == 0;
      mask_i     = (c == 0) ? m : ~m;  // R10: later mask changes are ignored
      susp_req_i = (ln > 0 && c >= st && c < st + ln);
      #3;
      adv = prev_cke;
      if (c > 0 && adv) tick++;
      exp_dqm = '0;
      if (rd && tick >= CL - 2 && tick < CL - 2 + BL) exp_dqm = m[(tick-CL+2)*LANES +: LANES];
      if (!rd && tick < BL) exp_dqm = m[tick*LANES +: LANES];
      chk(!adv ? "R8 dqm hold" : (rd ? "R4 read dqm" : "R3 write dqm"), dqm_o, exp_dqm);
      exp_rb   = rd && adv && tick >= CL && tick < CL + BL;
      exp_keep = exp_rb ? ~m[(tick-CL)*LANES +: LANES] : '0;
      chk("R5 rd_beat", rd_beat_o, exp_rb);
      chk("R5 R10 rd_keep", rd_keep_o, exp_keep);
      exp_wb = !rd && adv && tick < BL;
      chk("R6 wr_beat", wr_beat_o, exp_wb);
      chk("R1 cke", cke_o, !prev_susp);
      prev_susp = susp_req_i;
      prev_cke  = cke_o;
      if (adv && tick == last) fin = 1'b1;
    end
    chk("R2 burst ends", fin, 1'b1);
    if (settle) begin
      @(posedge clk_i); #1;
      rd_start_i = 0; wr_start_i = 0; susp_req_i = 0; mask_i = '0;
      repeat (2) @(posedge clk_i);
      #4;
      chk("R7 idle dqm", dqm_o, '0);
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #4;
    // R9 reset state
    chk("R9 cke", cke_o, 1'b1);
    chk("R9 dqm", dqm_o, '0);
    chk("R9 beats", {rd_beat_o, wr_beat_o}, 2'b00);
    @(posedge clk_i); #1 rst_ni = 1'b1;

    foreach (VEC[i])
      run_burst(VEC[i][24], VEC[i][23:16], int'(VEC[i][15:8]), int'(VEC[i][7:0]), 1'b1);

    // R7 back-to-back: read starts in the cycle after the write's last tick
    run_burst(1'b0, 8'hA5, 0, 0, 1'b0);
    run_burst(1'b1, 8'h6C, 0, 0, 1'b1);

    // R9 reset mid-burst discards it
    @(posedge clk_i); #1 rd_start_i = 1; mask_i = 8'hFF;
    @(posedge clk_i); #1 rd_start_i = 0; mask_i = '0;
    @(posedge clk_i); #1 rst_ni = 0;
    #1;
    chk("R9 mid cke", cke_o, 1'b1);
    chk("R9 mid dqm", dqm_o, '0);
    @(posedge clk_i); #1 rst_ni = 1;
    for (int c = 0; c < 6; c++) begin
      @(posedge clk_i); #4;
      chk("R9 discarded dqm", dqm_o, '0);
      chk("R9 discarded beat", rd_beat_o, 1'b0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule